// File: doc/BRIEF.md
# Four-Instruction Multicycle Processor Core

A small multicycle processor core for 4-bit data. It holds eight 4-bit general registers and a sixteen-word, 4-bit data memory, both kept in flip-flops. It executes 12-bit instructions of four kinds: memory-to-register load, register-to-memory store, and register add and subtract with results taken modulo 16. Each instruction is started by a one-cycle request pulse. A program-step request fetches the word at the program counter from a built-in instruction ROM. A switch-step request executes a 12-bit word supplied on an input bus.

Each accepted instruction passes through fetch, decode, execute and write-back phases, one clock each. When it completes, the core raises a one-cycle completion strobe. It also registers, for an external display driver, the two operand values, the result, and a flag that tells memory transfers from ALU operations. A clear request returns the program counter to zero and blanks the display values. It does not touch register or memory contents, which only the power-on reset initialises.

Top module: `quad_op_core`

## Requirements
- R1: After power-on reset (rst_n low), every register reads 0 and data memory word i holds i for i = 0..15. In the same state, pc is 0, done and busy are 0, and disp_a, disp_b, disp_res and disp_alu are 0.
- R2: Opcode field is bits [11:9]. Load is 000, with register index in [6:4] and memory address in [3:0]; bits [8:7] have no effect. Load copies memory[addr] into register[idx] and displays a=0, b=0, res=the value, alu=0.
- R3: Store is 001, with the same field layout as load. It copies register[idx] into memory[addr] and displays a=0, b=0, res=the value, alu=0.
- R4: Add is 101, with destination in [8:6], second source B in [5:3] and first source A in [2:0]. It writes (reg[A]+reg[B]) mod 16 to reg[dest] and displays a=reg[A], b=reg[B], res=the sum, alu=1.
- R5: Subtract is 110, with the same layout as add. It writes (reg[A]-reg[B]) mod 16 to reg[dest] and displays a=reg[A], b=reg[B], res=the difference, alu=1.
- R6: A request accepted on clock edge 0 holds busy high through edge 3 and lowers it at edge 4. For a defined opcode, done is high for exactly the single cycle after edge 4, together with the new display values.
- R7: Step requests that arrive while busy is high are ignored: no instruction is started, and neither pc nor storage changes because of them.
- R8: A program-step request runs ROM[pc] and then advances pc by one, wrapping from ROM_DEPTH-1 to 0. If both step requests arrive together, the program step wins.
- R9: A switch-step request runs the sw_instr value sampled on the accepting edge, and it leaves pc unchanged.
- R10: A clear request sets pc to 0 and disp_a, disp_b, disp_res and disp_alu to 0 on the next edge. Register and memory contents do not change.
- R11: An instruction with opcode 010, 011, 100 or 111 writes nothing and does not raise done. It leaves the display unchanged and still drops busy at edge 4. If it came from the ROM, pc still advances.
- R12: ROM word at address p, with k = p mod 8 and q = p mod 16, depends on p mod 4. For 0 it is a load of register k from memory address 15-q. For 1 it is an add with dest k, B=(k+7) mod 8 and A=(k+1) mod 8. For 2 it is a subtract with dest (k+3) mod 8, B=k and A=(k+2) mod 8. For 3 it is a store of register k to memory address (q+7) mod 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset; initialises storage and control |
| clr_req | input | 1 | Clear pulse: pc and display values to zero |
| step_rom | input | 1 | Run the ROM word at pc |
| step_sw | input | 1 | Run the word on sw_instr |
| sw_instr | input | 12 | Externally supplied instruction |
| busy | output | 1 | An instruction is in progress |
| pc | output | $clog2(ROM_DEPTH) | Program counter |
| done | output | 1 | One-cycle completion strobe |
| disp_a | output | 4 | First operand shown (0 for memory transfers) |
| disp_b | output | 4 | Second operand shown (0 for memory transfers) |
| disp_res | output | 4 | Result or transferred value |
| disp_alu | output | 1 | 1 for add/subtract, 0 for load/store |

## Verification
The bench builds the core with ROM_DEPTH set to 8, so the program counter wraps twice in a short ROM run. The ROM pattern is still broad enough to exercise all four opcodes at several register indices. Because data memory starts as the identity, every pair of 4-bit operands can be loaded from it. This allows a full 16 by 16 sweep of both add and subtract before any store disturbs the memory. A running model of registers, memory, pc and display in the bench then follows stores, undefined opcodes, clears and requests made while busy.

// File: rtl/qcore_pkg.sv
package qcore_pkg;
  localparam int DW   = 4;
  localparam int IW   = 12;
  localparam int RAW  = 3;
  localparam int MAW  = 4;
  localparam int RF_N = 1 << RAW;
  localparam int DM_N = 1 << MAW;

  localparam logic [2:0] OP_LD  = 3'b000;
  localparam logic [2:0] OP_ST  = 3'b001;
  localparam logic [2:0] OP_ADD = 3'b101;
  localparam logic [2:0] OP_SUB = 3'b110;

  typedef enum logic [2:0] {
    PH_IDLE, PH_FETCH, PH_DECODE, PH_EXEC, PH_WB
  } phase_t;

  function automatic logic [DW-1:0] alu_calc(input logic [DW-1:0] a,
                                             input logic [DW-1:0] b,
                                             input logic          sub);
    return sub ? (a - b) : (a + b);
  endfunction

  function automatic logic op_defined(input logic [2:0] op);
    return (op == OP_LD) || (op == OP_ST) || (op == OP_ADD) || (op == OP_SUB);
  endfunction

  // Built-in program: pattern chosen by the low two address bits
  function automatic logic [IW-1:0] rom_word(input int unsigned addr);
    logic [3:0] q;
    logic [2:0] k;
    q = 4'(addr);
    k = 3'(addr);
    case (q[1:0])
      2'd0:    return {OP_LD, 2'b00, k, ~q};
      2'd1:    return {OP_ADD, k, k - 3'd1, k + 3'd1};
      2'd2:    return {OP_SUB, k + 3'd3, k, k + 3'd2};
      default: return {OP_ST, 2'b00, k, q + 4'd7};
    endcase
  endfunction
endpackage

// File: rtl/qcore_irom.sv
module qcore_irom
  import qcore_pkg::*;
#(
  parameter int ROM_DEPTH = 16,
  localparam int PCW = $clog2(ROM_DEPTH)
) (
  input  logic [PCW-1:0] addr,
  output logic [IW-1:0]  word
);
  logic [IW-1:0] table_w [ROM_DEPTH];

  for (genvar i = 0; i < ROM_DEPTH; i++) begin : g_entry
    assign table_w[i] = rom_word(i);
  end

  assign word = table_w[addr];
endmodule

// File: rtl/qcore_ctrl.sv
module qcore_ctrl
  import qcore_pkg::*;
#(
  parameter int ROM_DEPTH = 16,
  localparam int PCW = $clog2(ROM_DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr_req,
  input  logic           step_rom,
  input  logic           step_sw,
  input  logic [IW-1:0]  sw_instr,
  input  logic [IW-1:0]  rom_data,
  output phase_t         phase,
  output logic [IW-1:0]  ir,
  output logic [PCW-1:0] pc
);
  localparam logic [PCW-1:0] PC_LAST = PCW'(ROM_DEPTH - 1);

  phase_t         phase_q;
  logic           src_rom_q;
  logic [IW-1:0]  sw_hold_q, ir_q;
  logic [PCW-1:0] pc_q;

  wire accept  = (phase_q == PH_IDLE) && (step_rom || step_sw);
  wire wb_fire = (phase_q == PH_WB);
  wire pc_adv  = wb_fire && src_rom_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      src_rom_q <= 1'b0;
      sw_hold_q <= '0;
      ir_q      <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: if (accept) begin
          phase_q   <= PH_FETCH;
          src_rom_q <= step_rom;
          sw_hold_q <= sw_instr;
        end
        PH_FETCH: begin
          ir_q    <= src_rom_q ? rom_data : sw_hold_q;
          phase_q <= PH_DECODE;
        end
        PH_DECODE: phase_q <= PH_EXEC;
        PH_EXEC:   phase_q <= PH_WB;
        default:   phase_q <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pc_q <= '0;
    else if (clr_req) pc_q <= '0;
    else if (pc_adv)  pc_q <= (pc_q == PC_LAST) ? '0 : pc_q + 1'b1;
  end

  assign phase = phase_q;
  assign ir    = ir_q;
  assign pc    = pc_q;

  AST_START_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE && (step_rom || step_sw)) |=> (phase_q == PH_FETCH)); // R6
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE) |=> (phase_q != PH_FETCH)); // R7
  AST_PC_SW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_fire && !src_rom_q && !clr_req) |=> $stable(pc_q)); // R9
  AST_PC_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_fire && src_rom_q && !clr_req && ROM_DEPTH > 1) |=> (pc_q != $past(pc_q))); // R8
  AST_PC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(pc_q) < ROM_DEPTH)); // R8
  AST_CLR_PC: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> (pc_q == '0)); // R10
endmodule

// File: rtl/qcore_dpath.sv
module qcore_dpath
  import qcore_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_req,
  input  phase_t        phase,
  input  logic [IW-1:0] ir,
  output logic          done,
  output logic [DW-1:0] disp_a,
  output logic [DW-1:0] disp_b,
  output logic [DW-1:0] disp_res,
  output logic          disp_alu
);
  logic [DW-1:0] rf_q [RF_N];
  logic [DW-1:0] dm_q [DM_N];
  logic [DW-1:0] opa_q, opb_q, res_q;
  logic [RF_N*DW-1:0] rf_flat;
  logic [DM_N*DW-1:0] dm_flat;

  wire [2:0]     op     = ir[11:9];
  wire [RAW-1:0] f_reg  = ir[6:4];
  wire [MAW-1:0] f_mem  = ir[3:0];
  wire [RAW-1:0] f_dst  = ir[8:6];
  wire [RAW-1:0] f_srcb = ir[5:3];
  wire [RAW-1:0] f_srca = ir[2:0];

  wire is_mem  = (op == OP_LD) || (op == OP_ST);
  wire is_alu  = (op == OP_ADD) || (op == OP_SUB);
  wire in_wb   = (phase == PH_WB);
  wire rf_we   = in_wb && ((op == OP_LD) || is_alu);
  wire dm_we   = in_wb && (op == OP_ST);
  wire fin_ok  = in_wb && op_defined(op);
  wire [RAW-1:0] rf_wa = (op == OP_LD) ? f_reg : f_dst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opa_q <= '0;
      opb_q <= '0;
      res_q <= '0;
    end else if (phase == PH_DECODE) begin
      if (is_mem) begin
        opa_q <= '0;
        opb_q <= '0;
        res_q <= (op == OP_LD) ? dm_q[f_mem] : rf_q[f_reg];
      end else begin
        opa_q <= rf_q[f_srca];
        opb_q <= rf_q[f_srcb];
      end
    end else if (phase == PH_EXEC && is_alu) begin
      res_q <= alu_calc(opa_q, opb_q, op == OP_SUB);
    end
  end

  for (genvar i = 0; i < RF_N; i++) begin : g_rf
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               rf_q[i] <= '0;
      else if (rf_we && rf_wa == RAW'(i))       rf_q[i] <= res_q;
    end
    assign rf_flat[i*DW +: DW] = rf_q[i];
  end

  for (genvar j = 0; j < DM_N; j++) begin : g_dm
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               dm_q[j] <= DW'(j);
      else if (dm_we && f_mem == MAW'(j))       dm_q[j] <= res_q;
    end
    assign dm_flat[j*DW +: DW] = dm_q[j];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      disp_a   <= '0;
      disp_b   <= '0;
      disp_res <= '0;
      disp_alu <= 1'b0;
    end else begin
      done <= fin_ok;
      if (clr_req) begin
        disp_a   <= '0;
        disp_b   <= '0;
        disp_res <= '0;
        disp_alu <= 1'b0;
      end else if (fin_ok) begin
        disp_a   <= opa_q;
        disp_b   <= opb_q;
        disp_res <= res_q;
        disp_alu <= is_alu;
      end
    end
  end

  AST_RF_WB_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_WB) |=> $stable(rf_flat)); // R11
  AST_DM_WB_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_WB) |=> $stable(dm_flat)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_CLR_DISPLAY: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> (disp_a == '0 && disp_b == '0 && disp_res == '0 && !disp_alu)); // R10
endmodule

// File: rtl/quad_op_core.sv
module quad_op_core
  import qcore_pkg::*;
#(
  parameter int ROM_DEPTH = 16,
  localparam int PCW = $clog2(ROM_DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr_req,
  input  logic           step_rom,
  input  logic           step_sw,
  input  logic [11:0]    sw_instr,
  output logic           busy,
  output logic [PCW-1:0] pc,
  output logic           done,
  output logic [3:0]     disp_a,
  output logic [3:0]     disp_b,
  output logic [3:0]     disp_res,
  output logic           disp_alu
);
  phase_t        phase;
  logic [IW-1:0] ir, rom_data;

  qcore_irom #(.ROM_DEPTH(ROM_DEPTH)) u_rom (
    .addr(pc),
    .word(rom_data)
  );

  qcore_ctrl #(.ROM_DEPTH(ROM_DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clr_req(clr_req),
    .step_rom(step_rom), .step_sw(step_sw), .sw_instr(sw_instr),
    .rom_data(rom_data), .phase(phase), .ir(ir), .pc(pc)
  );

  qcore_dpath u_dp (
    .clk(clk), .rst_n(rst_n), .clr_req(clr_req),
    .phase(phase), .ir(ir), .done(done),
    .disp_a(disp_a), .disp_b(disp_b), .disp_res(disp_res), .disp_alu(disp_alu)
  );

  assign busy = (phase != PH_IDLE);

  AST_DONE_AFTER_WB: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R6
endmodule

// File: tb/quad_op_core_test.sv
`timescale 1ns/1ps
module quad_op_core_test;
  localparam int ROMD = 8;

  logic clk = 1'b0, rst_n = 1'b0, clr_req = 1'b0, step_rom = 1'b0, step_sw = 1'b0;
  logic [11:0] sw_instr = '0;
  logic busy, done, disp_alu;
  logic [2:0] pc;
  logic [3:0] disp_a, disp_b, disp_res;

  int n_chk = 0, n_bad = 0;
  int m_rf [8];
  int m_dm [16];
  int m_pc = 0;
  int e_a = 0, e_b = 0, e_r = 0, e_alu = 0;

  always #2.5 clk = ~clk;

  quad_op_core #(.ROM_DEPTH(ROMD)) uut (
    .clk(clk), .rst_n(rst_n), .clr_req(clr_req), .step_rom(step_rom),
    .step_sw(step_sw), .sw_instr(sw_instr), .busy(busy), .pc(pc), .done(done),
    .disp_a(disp_a), .disp_b(disp_b), .disp_res(disp_res), .disp_alu(disp_alu)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R12: program pattern restated arithmetically
  function automatic int prog(input int p);
    int k = p % 8, q = p % 16;
    case (p % 4)
      0: return (0 << 9) + (k << 4) + (15 - q);
      1: return (5 << 9) + (k << 6) + (((k + 7) % 8) << 3) + ((k + 1) % 8);
      2: return (6 << 9) + (((k + 3) % 8) << 6) + (k << 3) + ((k + 2) % 8);
      default: return (1 << 9) + (k << 4) + ((q + 7) % 16);
    endcase
  endfunction

  function automatic int mk_ls(input int op, input int r, input int d, input int dc);
    return (op << 9) + (dc << 7) + (r << 4) + d;
  endfunction

  function automatic int mk_ar(input int op, input int w, input int b, input int a);
    return (op << 9) + (w << 6) + (b << 3) + a;
  endfunction

  // Reference execution; returns 1 for defined opcodes
  function automatic bit model(input int w);
    int op = (w >> 9) & 7;
    int r = (w >> 4) & 7, d = w & 15;
    int dst = (w >> 6) & 7, b = (w >> 3) & 7, a = w & 7;
    case (op)
      0: begin e_a = 0; e_b = 0; e_r = m_dm[d]; e_alu = 0; m_rf[r] = e_r; return 1; end
      1: begin e_a = 0; e_b = 0; e_r = m_rf[r]; e_alu = 0; m_dm[d] = e_r; return 1; end
      5: begin e_a = m_rf[a]; e_b = m_rf[b]; e_r = (e_a + e_b) % 16; e_alu = 1;
               m_rf[dst] = e_r; return 1; end
      6: begin e_a = m_rf[a]; e_b = m_rf[b]; e_r = (e_a - e_b + 16) % 16; e_alu = 1;
               m_rf[dst] = e_r; return 1; end
      default: return 0;
    endcase
  endfunction

  // mode 0: switch, 1: program, 2: both at once; intrude: extra requests while busy
  task automatic issue(input int mode, input int w, input bit intrude);
    int word;
    bit ok;
    @(negedge clk);
    if (mode != 0) step_rom = 1'b1;
    if (mode != 1) begin step_sw = 1'b1; sw_instr = 12'(w); end
    word = (mode == 0) ? w : prog(m_pc);
    @(negedge clk);
    step_rom = intrude; step_sw = intrude;
    sw_instr = ~12'(w);
    chk(busy == 1'b1, "R6 busy after accept", int'(busy), 1);
    chk(done == 1'b0, "R6 no early done", int'(done), 0);
    @(negedge clk);
    step_rom = 1'b0; step_sw = 1'b0;
    repeat (2) begin
      @(negedge clk);
      chk(done == 1'b0, "R6 no early done", int'(done), 0);
    end
    @(negedge clk);
    ok = model(word);
    if (mode != 0) m_pc = (m_pc + 1) % ROMD;
    chk(busy == 1'b0, "R6 idle at edge 4", int'(busy), 0);
    chk(done == ok, ok ? "R6 done strobe" : "R11 no done for undefined op", int'(done), int'(ok));
    chk(disp_a == 4'(e_a), "R2-R5 disp_a", int'(disp_a), e_a);
    chk(disp_b == 4'(e_b), "R4 R5 disp_b", int'(disp_b), e_b);
    chk(disp_res == 4'(e_r), "R2-R5 disp_res", int'(disp_res), e_r);
    chk(disp_alu == 1'(e_alu), "R2 R4 disp_alu", int'(disp_alu), e_alu);
    chk(int'(pc) == m_pc, (mode == 0) ? "R9 pc held" : "R8 pc advance", int'(pc), m_pc);
    @(negedge clk);
    chk(done == 1'b0, "R6 done one cycle", int'(done), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m_rf[i] = 0;
    for (int i = 0; i < 16; i++) m_dm[i] = i;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(pc == 3'd0, "R1 pc", int'(pc), 0);
    chk(done == 1'b0 && busy == 1'b0, "R1 done/busy", int'(done) + int'(busy), 0);
    chk(disp_a == 0 && disp_b == 0 && disp_res == 0 && !disp_alu, "R1 display",
        int'(disp_res), 0);
    // R1 registers zero (read through adds into r0)
    for (int i = 0; i < 8; i++) issue(0, mk_ar(5, 0, i, i), 1'b0);
    // R1 memory identity; R4/R5 full operand sweep, R2 don't-care bits
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        issue(0, mk_ls(0, 1, a, b % 4), 1'b0);
        issue(0, mk_ls(0, 2, b, a % 4), 1'b0);
        issue(0, mk_ar(5, 3, 2, 1), 1'b0);
        issue(0, mk_ar(6, 4, 2, 1), 1'b0);
      end
    // R3 stores then reloads
    for (int d = 0; d < 16; d++) issue(0, mk_ls(1, d % 8, d ^ 5, 0), 1'b0);
    for (int d = 0; d < 16; d++) issue(0, mk_ls(0, (d + 3) % 8, d, 0), 1'b0);
    // R8 R12 program run with wrap
    for (int s = 0; s < 2 * ROMD + 3; s++) issue(1, 0, 1'b0);
    // R8 both requests together: program wins
    issue(2, mk_ls(0, 7, 0, 0), 1'b0);
    issue(2, mk_ar(5, 7, 7, 7), 1'b0);
    // R10 clear: pc and display to zero, storage kept
    @(negedge clk);
    clr_req = 1'b1;
    @(negedge clk);
    clr_req = 1'b0;
    m_pc = 0; e_a = 0; e_b = 0; e_r = 0; e_alu = 0;
    chk(pc == 3'd0, "R10 pc cleared", int'(pc), 0);
    chk(disp_a == 0 && disp_b == 0 && disp_res == 0 && !disp_alu, "R10 display cleared",
        int'(disp_res), 0);
    for (int d = 0; d < 16; d++) issue(0, mk_ls(0, d % 8, d, 0), 1'b0);
    for (int i = 0; i < 8; i++) issue(0, mk_ar(5, 0, i, i), 1'b0);
    // R11 undefined opcodes: nothing written, display unchanged
    for (int u = 0; u < 4; u++) begin
      int uop = (u == 0) ? 2 : (u == 1) ? 3 : (u == 2) ? 4 : 7;
      issue(0, mk_ar(uop, u, 5, 6), 1'b0);
      issue(1, 0, 1'b0);
    end
    for (int i = 0; i < 8; i++) issue(0, mk_ar(5, 0, i, i), 1'b0);
    for (int d = 0; d < 16; d++) issue(0, mk_ls(0, d % 8, d, 0), 1'b0);
    // R7 requests during busy ignored
    for (int t = 0; t < 6; t++) begin
      issue(0, mk_ar(6, t % 8, (t + 1) % 8, 7), 1'b1);
      issue(1, 0, 1'b1);
    end
    for (int i = 0; i < 8; i++) issue(0, mk_ar(5, 0, i, i), 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule